// File: doc/BRIEF.md
# Shared Clock Lane Burst Controller

This block sequences the clock lane of a serial display or camera transmitter whose data lanes all run from one high-speed clock. The lane rests in LP-11. When a request arrives it makes the low-power entry handshake, drives HS-0 for a zero interval and then starts continuous high-speed clocking. After the clock has run for a pre interval, it sends the data-lane sequencers a single-cycle start grant. From that point it acknowledges the request.

When the request is withdrawn and every active data lane has left HS, the clock keeps running for a post interval. The lane then drives HS-0 as a trail with the clock stopped, returns to LP-11 and holds it for an exit interval. Only then does it accept a new burst. A request that reappears while the post interval is running cancels the shutdown: the burst carries on with no new entry sequence.

Each interval is an elaboration parameter counted in controller clock cycles. These cycle counts are set from the line rate so that the analog minima are met: prepare from 38 to 95 ns, prepare plus zero at least 300 ns, pre at least 8 UI, post at least 60 ns + 52 UI, and trail at least 60 ns. The number of active lanes is a run-time input. Lanes at or above that count are not monitored.

Top module: `clk_lane_burst_ctl`

## Requirements
- R1: During and right after reset, lineCode is 3'b011 (LP-11; bit 2 = HS driver on, bit 1 = P line, bit 0 = N line), hsClkEn is 0, ack is 0 and dataGo is 0.
- R2: A request seen in LP-11 idle makes the lane drive LP-01 (3'b001) for LPX_CYC cycles and then LP-00 (3'b000) for PREP_CYC cycles. HS (bit 2 high) is only ever entered straight from LP-00.
- R3: After prepare, the lane drives HS-0 (3'b100) with hsClkEn low for ZERO_CYC cycles.
- R4: hsClkEn is then high for PRE_CYC cycles. dataGo is a one-cycle pulse in the last of those cycles and is never given without a clock already running. ack rises in the following cycle.
- R5: While acknowledged, the controller stays in the clocking run state as long as req is high or any active lane reports HS.
- R6: Only lanes whose index is below laneCount are active. HS status on any other lane has no effect on shutdown.
- R7: Once req is low and no active lane is in HS, the clock runs for POST_CYC more cycles with ack low.
- R8: Clocking then stops, and the lane drives HS-0 with hsClkEn low for TRAIL_CYC cycles before it leaves HS. The lane leaves HS only from this clock-stopped HS-0 state.
- R9: After the trail, the lane holds LP-11 for EXIT_CYC cycles and ignores req during that time. It then spends one idle cycle in LP-11 before a pending request starts the LP-01 entry.
- R10: If req returns (or an active lane enters HS) during the post interval, ack is high again in the next cycle and clocking continues, with no LP state and no new dataGo in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Burst request from the link layer |
| laneHs | input | NUM_LANES | Per-lane flag, high while that data lane is in HS |
| laneCount | input | LCNT_W | Number of active lanes; lanes 0 to laneCount-1 are monitored |
| ack | output | 1 | High while the clock lane runs a burst and data may be sent |
| dataGo | output | 1 | One-cycle grant allowing data lanes to start HS entry |
| lineCode | output | 3 | Lane state: bit 2 HS driver, bits 1:0 LP line levels |
| hsClkEn | output | 1 | Enables the high-speed clock toggling |

## Verification
Every output is decoded from the registered state. A change of req, laneHs or laneCount therefore shows at the ports one clock edge later, and a phase of N cycles holds its code for exactly N samples. The bench drives inputs on the falling edge and samples on the next falling edge. It walks each phase with a sample count equal to its parameter, so that a phase too long or too short by one cycle fails at the boundary sample. dataGo is due in the last of the PRE_CYC clocking samples and ack in the sample after it. After a cancel, ack is due one sample after req returns. After the exit window, LP-01 is due EXIT_CYC + 1 samples after the trail ends.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

  // Line codes: bit 2 = HS driver enabled, bit 1 = P line, bit 0 = N line
  localparam logic [2:0] LC_LP11 = 3'b011;
  localparam logic [2:0] LC_LP01 = 3'b001;
  localparam logic [2:0] LC_LP00 = 3'b000;
  localparam logic [2:0] LC_HS0  = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LPREQ,
    ST_PREP,
    ST_ZERO,
    ST_PRE,
    ST_RUN,
    ST_POST,
    ST_TRAIL,
    ST_EXIT
  } laneState_e;

  typedef enum logic [2:0] {
    IV_LPX,
    IV_PREP,
    IV_ZERO,
    IV_PRE,
    IV_POST,
    IV_TRAIL,
    IV_EXIT
  } interval_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      load;
    interval_e sel;
  } timerCmd_t;

endpackage

// File: rtl/clk_lane_dpath.sv
module clk_lane_dpath
  import clk_lane_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 8,
  parameter int LPX_CYC   = 2,
  parameter int PREP_CYC  = 3,
  parameter int ZERO_CYC  = 10,
  parameter int PRE_CYC   = 4,
  parameter int POST_CYC  = 6,
  parameter int TRAIL_CYC = 3,
  parameter int EXIT_CYC  = 4,
  localparam int LCNT_W   = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  timerCmd_t            cmd,
  input  logic [NUM_LANES-1:0] laneHs,
  input  logic [LCNT_W-1:0]    laneCount,
  output logic                 expired,
  output logic                 activeHs
);

  // Reload values are one less than the phase length: a phase of N
  // cycles sees the counter at N-1 down to 0.
  localparam logic [CNT_W-1:0] LD_LPX   = CNT_W'(LPX_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PREP  = CNT_W'(PREP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ZERO  = CNT_W'(ZERO_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PRE   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_POST  = CNT_W'(POST_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRAIL = CNT_W'(TRAIL_CYC - 1);
  localparam logic [CNT_W-1:0] LD_EXIT  = CNT_W'(EXIT_CYC - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (cmd.sel)
      IV_LPX:   loadVal = LD_LPX;
      IV_PREP:  loadVal = LD_PREP;
      IV_ZERO:  loadVal = LD_ZERO;
      IV_PRE:   loadVal = LD_PRE;
      IV_POST:  loadVal = LD_POST;
      IV_TRAIL: loadVal = LD_TRAIL;
      IV_EXIT:  loadVal = LD_EXIT;
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (cmd.load) begin
      phaseCnt <= loadVal;
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - 1'b1;
    end
  end

  assign expired = (phaseCnt == '0);

  // Active-lane mask: lane i is watched only when i < laneCount
  logic [NUM_LANES-1:0] activeMask;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_mask
    assign activeMask[i] = (laneCount > LCNT_W'(i));
  end

  assign activeHs = |(laneHs & activeMask);

endmodule

// File: rtl/clk_lane_ctrl.sv
module clk_lane_ctrl
  import clk_lane_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       expired,
  input  logic       activeHs,
  output timerCmd_t  cmd,
  output logic       ack,
  output logic       dataGo,
  output logic [2:0] lineCode,
  output logic       hsClkEn
);

  laneState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  logic keepRunning;
  assign keepRunning = req || activeHs;

  always_comb begin
    nextState = state;
    cmd.load  = 1'b0;
    cmd.sel   = IV_LPX;
    unique case (state)
      ST_IDLE: if (req) begin
        nextState = ST_LPREQ;
        cmd.load  = 1'b1;
        cmd.sel   = IV_LPX;
      end
      ST_LPREQ: if (expired) begin
        nextState = ST_PREP;
        cmd.load  = 1'b1;
        cmd.sel   = IV_PREP;
      end
      ST_PREP: if (expired) begin
        nextState = ST_ZERO;
        cmd.load  = 1'b1;
        cmd.sel   = IV_ZERO;
      end
      ST_ZERO: if (expired) begin
        nextState = ST_PRE;
        cmd.load  = 1'b1;
        cmd.sel   = IV_PRE;
      end
      ST_PRE: if (expired) nextState = ST_RUN;
      ST_RUN: if (!keepRunning) begin
        nextState = ST_POST;
        cmd.load  = 1'b1;
        cmd.sel   = IV_POST;
      end
      ST_POST: begin
        if (keepRunning) begin
          nextState = ST_RUN;
        end else if (expired) begin
          nextState = ST_TRAIL;
          cmd.load  = 1'b1;
          cmd.sel   = IV_TRAIL;
        end
      end
      ST_TRAIL: if (expired) begin
        nextState = ST_EXIT;
        cmd.load  = 1'b1;
        cmd.sel   = IV_EXIT;
      end
      ST_EXIT: if (expired) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    lineCode = LC_LP11;
    hsClkEn  = 1'b0;
    unique case (state)
      ST_IDLE, ST_EXIT: lineCode = LC_LP11;
      ST_LPREQ:         lineCode = LC_LP01;
      ST_PREP:          lineCode = LC_LP00;
      ST_ZERO, ST_TRAIL: lineCode = LC_HS0;
      ST_PRE, ST_RUN, ST_POST: begin
        lineCode = LC_HS0;
        hsClkEn  = 1'b1;
      end
      default:          lineCode = LC_LP11;
    endcase
  end

  assign ack    = (state == ST_RUN);
  assign dataGo = (state == ST_PRE) && expired;

endmodule

// File: rtl/clk_lane_burst_ctl.sv
module clk_lane_burst_ctl
  import clk_lane_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 8,
  parameter int LPX_CYC   = 2,
  parameter int PREP_CYC  = 3,
  parameter int ZERO_CYC  = 10,
  parameter int PRE_CYC   = 4,
  parameter int POST_CYC  = 6,
  parameter int TRAIL_CYC = 3,
  parameter int EXIT_CYC  = 4,
  localparam int LCNT_W   = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 req,
  input  logic [NUM_LANES-1:0] laneHs,
  input  logic [LCNT_W-1:0]    laneCount,
  output logic                 ack,
  output logic                 dataGo,
  output logic [2:0]           lineCode,
  output logic                 hsClkEn
);

  timerCmd_t timerCmd;
  logic      expired;
  logic      activeHs;

  clk_lane_dpath #(
    .NUM_LANES (NUM_LANES),
    .CNT_W     (CNT_W),
    .LPX_CYC   (LPX_CYC),
    .PREP_CYC  (PREP_CYC),
    .ZERO_CYC  (ZERO_CYC),
    .PRE_CYC   (PRE_CYC),
    .POST_CYC  (POST_CYC),
    .TRAIL_CYC (TRAIL_CYC),
    .EXIT_CYC  (EXIT_CYC)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (timerCmd),
    .laneHs    (laneHs),
    .laneCount (laneCount),
    .expired   (expired),
    .activeHs  (activeHs)
  );

  clk_lane_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .req      (req),
    .expired  (expired),
    .activeHs (activeHs),
    .cmd      (timerCmd),
    .ack      (ack),
    .dataGo   (dataGo),
    .lineCode (lineCode),
    .hsClkEn  (hsClkEn)
  );

endmodule

// File: rtl/clk_lane_burst_chk.sv
module clk_lane_burst_chk #(
  parameter int NUM_LANES = 4,
  localparam int LCNT_W   = $clog2(NUM_LANES + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 req,
  input logic [NUM_LANES-1:0] laneHs,
  input logic [LCNT_W-1:0]    laneCount,
  input logic                 ack,
  input logic                 dataGo,
  input logic [2:0]           lineCode,
  input logic                 hsClkEn
);

  logic [NUM_LANES-1:0] watched;
  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) watched[i] = (i < int'(laneCount));
  end

  p_go_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataGo |=> !dataGo);

  p_go_after_clock_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataGo |-> (hsClkEn && $past(hsClkEn)));

  p_hs_from_lp00_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineCode[2]) |-> ($past(lineCode) == 3'b000));

  p_leave_hs_after_trail_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineCode[2]) |-> ($past(lineCode) == 3'b100 && !$past(hsClkEn)));

  p_clk_stop_in_hs0_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsClkEn) |-> (lineCode == 3'b100));

  p_ack_clocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (hsClkEn && lineCode == 3'b100));

  p_active_lane_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ack && (req || (|(laneHs & watched)))) |=> ack);

  p_ack_no_lp_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> ($past(dataGo) || $past(hsClkEn)));

  p_idle_clock_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lineCode[2] == 1'b0) |-> (!hsClkEn && !ack && !dataGo));

endmodule

bind clk_lane_burst_ctl clk_lane_burst_chk #(.NUM_LANES(NUM_LANES)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .req       (req),
  .laneHs    (laneHs),
  .laneCount (laneCount),
  .ack       (ack),
  .dataGo    (dataGo),
  .lineCode  (lineCode),
  .hsClkEn   (hsClkEn)
);

// File: tb/test_clk_lane_burst_ctl.sv
module test_clk_lane_burst_ctl;

  localparam int NL    = 4;
  localparam int LW    = $clog2(NL + 1);
  localparam int LPX   = 2;
  localparam int PREP  = 3;
  localparam int ZERO  = 10;
  localparam int PRE   = 4;
  localparam int POST  = 6;
  localparam int TRAIL = 3;
  localparam int EXIT  = 4;

  localparam logic [2:0] LP11 = 3'b011;
  localparam logic [2:0] LP01 = 3'b001;
  localparam logic [2:0] LP00 = 3'b000;
  localparam logic [2:0] HS0  = 3'b100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          req = 1'b0;
  logic [NL-1:0] laneHs = '0;
  logic [LW-1:0] laneCount = LW'(NL);
  logic          ack, dataGo, hsClkEn;
  logic [2:0]    lineCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  clk_lane_burst_ctl #(
    .NUM_LANES(NL), .CNT_W(8), .LPX_CYC(LPX), .PREP_CYC(PREP),
    .ZERO_CYC(ZERO), .PRE_CYC(PRE), .POST_CYC(POST),
    .TRAIL_CYC(TRAIL), .EXIT_CYC(EXIT)
  ) i_clk_lane_burst_ctl (
    .clk(clk), .rstN(rstN), .req(req), .laneHs(laneHs),
    .laneCount(laneCount), .ack(ack), .dataGo(dataGo),
    .lineCode(lineCode), .hsClkEn(hsClkEn)
  );

  // Compare {lineCode, hsClkEn, ack, dataGo} at the present moment
  task automatic compareNow(input logic [2:0] code, input bit clkE,
                            input bit ackE, input bit goE, input string tag);
    logic [5:0] act, exp;
    act = {lineCode, hsClkEn, ack, dataGo};
    exp = {code, clkE, ackE, goE};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: {code,clk,ack,go} got %b expected %b",
               tag, $time, act, exp);
    end
  endtask

  task automatic sampleCheck(input logic [2:0] code, input bit clkE,
                             input bit ackE, input bit goE, input string tag);
    @(negedge clk);
    compareNow(code, clkE, ackE, goE, tag);
  endtask

  task automatic holdCheck(input logic [2:0] code, input bit clkE,
                           input bit ackE, input int n, input string tag);
    for (int k = 0; k < n; k++) sampleCheck(code, clkE, ackE, 1'b0, tag);
  endtask

  // Entry phases after req was seen in idle (R2, R3, R4)
  task automatic checkEntry();
    holdCheck(LP01, 1'b0, 1'b0, LPX, "R2 lp01");
    holdCheck(LP00, 1'b0, 1'b0, PREP, "R2 prepare");
    holdCheck(HS0, 1'b0, 1'b0, ZERO, "R3 zero");
    holdCheck(HS0, 1'b1, 1'b0, PRE - 1, "R4 pre");
    sampleCheck(HS0, 1'b1, 1'b0, 1'b1, "R4 grant");
    sampleCheck(HS0, 1'b1, 1'b1, 1'b0, "R4 ack after grant");
  endtask

  // Shutdown after the stop condition was applied on the previous negedge
  task automatic exitSeq(input bit raiseInExit, input string postTag);
    holdCheck(HS0, 1'b1, 1'b0, POST, postTag);
    holdCheck(HS0, 1'b0, 1'b0, TRAIL, "R8 trail");
    sampleCheck(LP11, 1'b0, 1'b0, 1'b0, "R9 exit start");
    if (raiseInExit) req = 1'b1;
    holdCheck(LP11, 1'b0, 1'b0, EXIT, "R9 exit hold");
    if (raiseInExit) checkEntry();
  endtask

  task automatic testReset();
    rstN = 1'b0;
    req  = 1'b1;
    repeat (2) @(negedge clk);
    compareNow(LP11, 1'b0, 1'b0, 1'b0, "R1 in reset");
    req  = 1'b0;
    rstN = 1'b1;
    holdCheck(LP11, 1'b0, 1'b0, 2, "R1 after reset");
  endtask

  task automatic testEntryRun();
    laneCount = LW'(NL);
    req = 1'b1;
    checkEntry();
    holdCheck(HS0, 1'b1, 1'b1, 5, "R5 req holds run");
  endtask

  task automatic testLaneMask();
    laneCount = LW'(2);
    laneHs = 4'b0010;
    req = 1'b0;
    holdCheck(HS0, 1'b1, 1'b1, 6, "R5 active lane holds run");
    laneHs = 4'b1000;
    exitSeq(1'b0, "R6 R7 inactive lane ignored, post");
    laneHs = '0;
  endtask

  task automatic testExitIgnore();
    laneCount = LW'(NL);
    req = 1'b1;
    checkEntry();
    req = 1'b0;
    exitSeq(1'b1, "R7 post");
  endtask

  task automatic testCancel();
    req = 1'b0;
    holdCheck(HS0, 1'b1, 1'b0, 2, "R10 post before cancel");
    req = 1'b1;
    sampleCheck(HS0, 1'b1, 1'b1, 1'b0, "R10 ack back");
    holdCheck(HS0, 1'b1, 1'b1, 3, "R10 continues");
    req = 1'b0;
    exitSeq(1'b0, "R7 post after cancel");
    holdCheck(LP11, 1'b0, 1'b0, 2, "R9 stays idle");
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    testReset();
    testEntryRun();
    testLaneMask();
    testExitIgnore();
    testCancel();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      finishRun();
    end
  end

endmodule